// File: doc/BRIEF.md
# Load/Store Address Generator

This block works out where a single-register load or store goes and what the base register holds afterwards. It receives the fields that the instruction decoder has already split out, along with the base and index register values, the current program counter and the current privilege state. It returns the transfer address, the transfer size, the privilege level that applies to this one access, and the new base value with its write enable. It also raises a flag when the decoded fields form a combination that is not allowed.

The offset is either a 12-bit unsigned byte count or the index register passed through a barrel shift by a constant amount. The offset is added to the base or subtracted from it. With pre-indexing the result is the transfer address and is written back only on request. With post-indexing the unmodified base goes to the bus and the result is always written back. A post-indexed access can ask to be carried out as non-privileged.

The arithmetic is combinational. A parameter adds one output register stage with a valid flag. By default that stage is present, so results appear one clock after `in_valid`.

Top module: `ldst_agu`

## Requirements
- R1: With `pre_sel`=1, `xfer_addr` equals the base plus or minus the offset, and `wb_en` equals `wb_req`. `wb_val` always carries that same sum.
- R2: With `pre_sel`=0, `xfer_addr` equals the unmodified base, `wb_val` equals the base plus or minus the offset, and `wb_en` is 1.
- R3: `up_sel`=1 adds the offset and `up_sel`=0 subtracts it. All address arithmetic wraps modulo 2^32 and has no overflow indication.
- R4: With `reg_off_sel`=0, the offset is `imm_off` zero-extended to 32 bits. An immediate of 0 leaves the base unchanged.
- R5: With `reg_off_sel`=1 and a nonzero `shift_amt`, the offset is `idx_val` shifted by `shift_amt`. The `shift_kind` encoding is 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right.
- R6: With `shift_amt`=0, the shift kinds behave as follows. Logical left passes `idx_val` unchanged. Logical right gives 0, the same as a shift by 32. Arithmetic right gives 32 copies of `idx_val[31]`. Rotate right gives `{carry_in, idx_val[31:1]}`.
- R7: `xfer_byte` equals `byte_sel` (1 = single byte, 0 = 32-bit word), and `xfer_load` equals `ld_sel`.
- R8: `eff_priv` equals `priv_in`, except that it is 0 when `xlat_req`=1 and `pre_sel`=0.
- R9: With `base_is_pc`=1, the base used is `pc_val`+8, and `base_val` is ignored.
- R10: With `base_is_pc`=1, `wb_en` is 0. `bad_combo` is 1 if a write-back would otherwise have occurred, that is, for pre-indexing with `wb_req`=1 or for any post-indexing.
- R11: With `xlat_req`=1 and `pre_sel`=1, `bad_combo` is 1 and `eff_priv` stays equal to `priv_in`.
- R12: With the output stage present, the outputs update one clock after a cycle with `in_valid`=1, and `out_valid` follows `in_valid` one clock later. In cycles with `in_valid`=0 the outputs hold their values. Synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input fields are valid this cycle |
| ld_sel | input | 1 | 1 = load, 0 = store |
| byte_sel | input | 1 | 1 = byte transfer, 0 = word transfer |
| pre_sel | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| up_sel | input | 1 | 1 = add offset, 0 = subtract offset |
| wb_req | input | 1 | Base write-back requested (pre-indexed) |
| xlat_req | input | 1 | Force a non-privileged access (post-indexed) |
| reg_off_sel | input | 1 | 1 = shifted index register, 0 = immediate |
| imm_off | input | 12 | Immediate byte offset |
| base_is_pc | input | 1 | Base register is the program counter |
| base_val | input | 32 | Base register value |
| idx_val | input | 32 | Index register value |
| shift_kind | input | 2 | Shift type for the index register |
| shift_amt | input | 5 | Constant shift amount |
| carry_in | input | 1 | Carry shifted in by rotate with amount 0 |
| pc_val | input | 32 | Address of the current instruction |
| priv_in | input | 1 | Current privilege state (1 = privileged) |
| out_valid | output | 1 | Outputs carry a new result |
| xfer_addr | output | 32 | Transfer address |
| xfer_load | output | 1 | Transfer direction (1 = load) |
| xfer_byte | output | 1 | Transfer size (1 = byte) |
| eff_priv | output | 1 | Privilege level for this transfer |
| wb_val | output | 32 | New base register value |
| wb_en | output | 1 | Base write-back enable |
| bad_combo | output | 1 | Illegal field combination detected |

## Verification
Assertions check four things on every valid cycle:
- A pre-indexed address matches the write-back value.
- A post-indexed address is the raw base.
- A translated post-indexed access never runs privileged.
- A program-counter base never enables write-back.

At the register stage, assertions also check the valid timing and that outputs hold while idle.

The bench scenarios cover what a local property cannot show: the actual offset values for each shift type, the amount-zero cases (including the carry entering a rotate), wrap-around in both directions, the +8 program-counter adjustment, and the illegal-combination flag. The bench also confirms that the base input is ignored when the program counter is the base.

// File: rtl/agu_pkg.sv
// Package: shared widths, shift encoding and the result bundle of the
// load/store address generator. Assumes a 32-bit data path.
package agu_pkg;
    parameter int unsigned AGU_DW     = 32;
    parameter int unsigned AGU_IMM_W  = 12;
    parameter int unsigned AGU_SHW    = $clog2(AGU_DW);
    parameter int unsigned AGU_PC_ADJ = 8;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } agu_shift_e;

    typedef struct packed {
        logic [AGU_DW-1:0] addr;
        logic              is_load;
        logic              is_byte;
        logic              priv;
        logic [AGU_DW-1:0] wb_val;
        logic              wb_en;
        logic              bad;
    } agu_result_t;
endpackage

// File: rtl/agu_offset_shift.sv
// Module: agu_offset_shift
// Shifts the index register by a constant amount. An amount of zero
// selects the special meanings: right shifts act as a shift by the full
// width, and rotate becomes a one-bit rotate through the carry input.
// Assumes the amount never comes from a register. Purely combinational.
module agu_offset_shift
    import agu_pkg::*;
#(
    parameter int unsigned DW  = AGU_DW,
    parameter int unsigned SHW = $clog2(DW)
) (
    input  logic [DW-1:0]  val,
    input  agu_shift_e     kind,
    input  logic [SHW-1:0] amt,
    input  logic           cin,
    output logic [DW-1:0]  res
);
    logic           amt_zero;
    logic [SHW-1:0] neg_amt;

    // Flag the amount-zero case and form the complementary rotate amount.
    always_comb begin
        amt_zero = (amt == '0);
        neg_amt  = SHW'(0) - amt;
    end

    // Select the shifter result for the requested kind.
    always_comb begin
        unique case (kind)
            SH_LSL:  res = val << amt;
            SH_LSR:  res = amt_zero ? '0 : (val >> amt);
            SH_ASR:  res = amt_zero ? {DW{val[DW-1]}}
                                    : DW'(unsigned'($signed(val) >>> amt));
            default: res = amt_zero ? {cin, val[DW-1:1]}
                                    : ((val >> amt) | (val << neg_amt));
        endcase
    end
endmodule

// File: rtl/agu_addr_calc.sv
// Module: agu_addr_calc
// Selects the base (the program counter plus a fixed adjustment when the
// base is the program counter), adds or subtracts the offset modulo 2^DW,
// and derives the address, write-back, privilege and illegal-combination
// outputs. Assumes the offset is already shifted or extended. Combinational.
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int unsigned DW     = AGU_DW,
    parameter int unsigned PC_ADJ = AGU_PC_ADJ
) (
    input  logic          ld_sel,
    input  logic          byte_sel,
    input  logic          pre_sel,
    input  logic          up_sel,
    input  logic          wb_req,
    input  logic          xlat_req,
    input  logic          base_is_pc,
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] pc_val,
    input  logic [DW-1:0] offset,
    input  logic          priv_in,
    output agu_result_t   res
);
    localparam logic [DW-1:0] PC_OFS = DW'(PC_ADJ);

    logic [DW-1:0] base_eff;
    logic [DW-1:0] sum;
    logic          wants_wb;

    // Choose the effective base and apply the offset in the given direction.
    always_comb begin
        base_eff = base_is_pc ? (pc_val + PC_OFS) : base_val;
        sum      = up_sel ? (base_eff + offset) : (base_eff - offset);
    end

    // A write-back is implied by post-indexing or requested by pre-indexing.
    always_comb wants_wb = pre_sel ? wb_req : 1'b1;

    // Build the result bundle.
    always_comb begin
        res.addr    = pre_sel ? sum : base_eff;
        res.is_load = ld_sel;
        res.is_byte = byte_sel;
        res.priv    = priv_in & ~(xlat_req & ~pre_sel);
        res.wb_val  = sum;
        res.wb_en   = wants_wb & ~base_is_pc;
        res.bad     = (base_is_pc & wants_wb) | (xlat_req & pre_sel);
    end
endmodule

// File: rtl/agu_out_stage.sv
// Module: agu_out_stage
// Optional output register. With OUT_REG=1 the result is captured on a
// valid cycle and held otherwise, and the valid flag is delayed one clock.
// With OUT_REG=0 it is a wire. Synchronous active-low reset clears all.
module agu_out_stage
    import agu_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  agu_result_t d,
    output logic        q_valid,
    output agu_result_t q
);
    generate
        if (OUT_REG) begin : g_reg
            // Capture the result on a valid cycle and track the valid flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_valid <= 1'b0;
                    q       <= '0;
                end else begin
                    q_valid <= in_valid;
                    if (in_valid) q <= d;
                end
            end

            // R12: valid is delayed by exactly one clock.
            a_r12_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (q_valid == $past(in_valid)));
            // R12: the outputs hold across an idle cycle.
            a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(in_valid)) |-> $stable(q));
        end else begin : g_comb
            // Pass the result straight through.
            always_comb begin
                q_valid = in_valid;
                q       = d;
            end
        end
    endgenerate
endmodule

// File: rtl/ldst_agu.sv
// Module: ldst_agu (top)
// Address generator for a single-register load or store. It shifts or
// extends the offset, forms the address and base write-back, and
// optionally registers the outputs. Assumes the decoder supplies the fields
// and the register file supplies the values in the same cycle.
module ldst_agu
    import agu_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 ld_sel,
    input  logic                 byte_sel,
    input  logic                 pre_sel,
    input  logic                 up_sel,
    input  logic                 wb_req,
    input  logic                 xlat_req,
    input  logic                 reg_off_sel,
    input  logic [AGU_IMM_W-1:0] imm_off,
    input  logic                 base_is_pc,
    input  logic [AGU_DW-1:0]    base_val,
    input  logic [AGU_DW-1:0]    idx_val,
    input  logic [1:0]           shift_kind,
    input  logic [AGU_SHW-1:0]   shift_amt,
    input  logic                 carry_in,
    input  logic [AGU_DW-1:0]    pc_val,
    input  logic                 priv_in,
    output logic                 out_valid,
    output logic [AGU_DW-1:0]    xfer_addr,
    output logic                 xfer_load,
    output logic                 xfer_byte,
    output logic                 eff_priv,
    output logic [AGU_DW-1:0]    wb_val,
    output logic                 wb_en,
    output logic                 bad_combo
);
    logic [AGU_DW-1:0] shifted;
    logic [AGU_DW-1:0] offset;
    agu_result_t       res_c;
    agu_result_t       res_q;

    agu_offset_shift #(.DW(AGU_DW), .SHW(AGU_SHW)) u_shift (
        .val  (idx_val),
        .kind (agu_shift_e'(shift_kind)),
        .amt  (shift_amt),
        .cin  (carry_in),
        .res  (shifted)
    );

    // Pick the register-derived or the zero-extended immediate offset.
    always_comb offset = reg_off_sel ? shifted : AGU_DW'(imm_off);

    agu_addr_calc #(.DW(AGU_DW), .PC_ADJ(AGU_PC_ADJ)) u_calc (
        .ld_sel     (ld_sel),
        .byte_sel   (byte_sel),
        .pre_sel    (pre_sel),
        .up_sel     (up_sel),
        .wb_req     (wb_req),
        .xlat_req   (xlat_req),
        .base_is_pc (base_is_pc),
        .base_val   (base_val),
        .pc_val     (pc_val),
        .offset     (offset),
        .priv_in    (priv_in),
        .res        (res_c)
    );

    agu_out_stage #(.OUT_REG(OUT_REG)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d        (res_c),
        .q_valid  (out_valid),
        .q        (res_q)
    );

    // Unpack the result bundle onto the ports.
    always_comb begin
        xfer_addr = res_q.addr;
        xfer_load = res_q.is_load;
        xfer_byte = res_q.is_byte;
        eff_priv  = res_q.priv;
        wb_val    = res_q.wb_val;
        wb_en     = res_q.wb_en;
        bad_combo = res_q.bad;
    end

    // R1: a pre-indexed address equals the value written back.
    a_r1_pre_addr_is_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pre_sel) |-> (res_c.addr == res_c.wb_val));
    // R2: a post-indexed address is the raw base register.
    a_r2_post_addr_is_base: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pre_sel && !base_is_pc) |-> (res_c.addr == base_val));
    // R8: a translated post-indexed transfer is never privileged.
    a_r8_xlat_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xlat_req && !pre_sel) |-> !res_c.priv);
    // R10: a program-counter base never writes back.
    a_r10_pc_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && base_is_pc) |-> !res_c.wb_en);
endmodule

// File: tb/ldst_agu_tb.sv
`timescale 1ns/1ps
// Directed bench for ldst_agu: one task per scenario, each checking its
// own results against a model built from the requirements.
module ldst_agu_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, ld_sel, byte_sel, pre_sel, up_sel, wb_req, xlat_req;
    logic        reg_off_sel, base_is_pc, carry_in, priv_in;
    logic [11:0] imm_off;
    logic [31:0] base_val, idx_val, pc_val;
    logic [1:0]  shift_kind;
    logic [4:0]  shift_amt;
    logic        out_valid, xfer_load, xfer_byte, eff_priv, wb_en, bad_combo;
    logic [31:0] xfer_addr, wb_val;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] last_addr;

    always #2 clk = ~clk;

    ldst_agu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ld_sel(ld_sel),
        .byte_sel(byte_sel), .pre_sel(pre_sel), .up_sel(up_sel), .wb_req(wb_req),
        .xlat_req(xlat_req), .reg_off_sel(reg_off_sel), .imm_off(imm_off),
        .base_is_pc(base_is_pc), .base_val(base_val), .idx_val(idx_val),
        .shift_kind(shift_kind), .shift_amt(shift_amt), .carry_in(carry_in),
        .pc_val(pc_val), .priv_in(priv_in), .out_valid(out_valid),
        .xfer_addr(xfer_addr), .xfer_load(xfer_load), .xfer_byte(xfer_byte),
        .eff_priv(eff_priv), .wb_val(wb_val), .wb_en(wb_en), .bad_combo(bad_combo)
    );

    // Model of the index shift (R5, R6).
    function automatic logic [31:0] m_shift(logic [31:0] x, logic [1:0] k,
                                            logic [4:0] a, logic c);
        logic [63:0] dbl;
        dbl = {x, x} >> a;
        case (k)
            2'd0: return x << a;
            2'd1: return (a == 0) ? 32'd0 : x >> a;
            2'd2: return (a == 0) ? {32{x[31]}} : 32'($signed(x) >>> a);
            default: return (a == 0) ? {c, x[31:1]} : dbl[31:0];
        endcase
    endfunction

    task automatic check_one(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply the current inputs for one valid cycle and compare all outputs.
    task automatic fire(string req);
        logic [31:0] b, off, s, e_addr;
        logic e_wben, e_priv, e_bad, e_wants;
        b     = base_is_pc ? pc_val + 32'd8 : base_val;
        off   = reg_off_sel ? m_shift(idx_val, shift_kind, shift_amt, carry_in)
                            : {20'd0, imm_off};
        s     = up_sel ? b + off : b - off;
        e_addr  = pre_sel ? s : b;
        e_wants = pre_sel ? wb_req : 1'b1;
        e_wben  = e_wants && !base_is_pc;
        e_priv  = priv_in && !(xlat_req && !pre_sel);
        e_bad   = (base_is_pc && e_wants) || (xlat_req && pre_sel);
        in_valid = 1'b1;
        @(negedge clk);
        check_one(req, "addr", xfer_addr, e_addr);
        check_one(req, "wb_val", wb_val, s);
        check_one(req, "flags",
                  {26'd0, out_valid, wb_en, eff_priv, bad_combo, xfer_byte, xfer_load},
                  {26'd0, 1'b1, e_wben, e_priv, e_bad, byte_sel, ld_sel});
        last_addr = e_addr;
    endtask

    task automatic defaults();
        in_valid = 0; ld_sel = 1; byte_sel = 0; pre_sel = 1; up_sel = 1;
        wb_req = 0; xlat_req = 0; reg_off_sel = 0; imm_off = 12'h000;
        base_is_pc = 0; base_val = 32'h0000_1000; idx_val = 32'h0;
        shift_kind = 2'd0; shift_amt = 5'd0; carry_in = 0;
        pc_val = 32'h0000_8000; priv_in = 1;
    endtask

    task automatic t_reset();
        check_one("R12", "reset outputs",
                  {out_valid, wb_en, eff_priv, bad_combo, xfer_byte, xfer_load} ^ xfer_addr ^ wb_val,
                  32'd0);
    endtask

    task automatic t_pre_index();
        defaults(); imm_off = 12'h0FC; wb_req = 0; fire("R1");
        wb_req = 1; up_sel = 0; fire("R1");
        imm_off = 12'h000; fire("R4");
        imm_off = 12'hFFF; up_sel = 1; fire("R4");
    endtask

    task automatic t_post_index();
        defaults(); pre_sel = 0; imm_off = 12'h010; fire("R2");
        up_sel = 0; ld_sel = 0; fire("R2");
    endtask

    task automatic t_wrap();
        defaults(); base_val = 32'hFFFF_FFF0; imm_off = 12'h020; fire("R3");
        base_val = 32'h0000_0004; up_sel = 0; imm_off = 12'h008; fire("R3");
    endtask

    task automatic t_shifts();
        defaults(); reg_off_sel = 1; idx_val = 32'h8000_00F1;
        for (int k = 0; k < 4; k++) begin
            shift_kind = 2'(k); shift_amt = 5'd4; fire("R5");
            shift_amt = 5'd31; fire("R5");
        end
    endtask

    task automatic t_shift_zero();
        defaults(); reg_off_sel = 1; idx_val = 32'h8000_0003; shift_amt = 5'd0;
        for (int k = 0; k < 4; k++) begin
            shift_kind = 2'(k); carry_in = 1'b0; fire("R6");
        end
        shift_kind = 2'd3; carry_in = 1'b1; fire("R6");
        idx_val = 32'h4000_0000; shift_kind = 2'd2; fire("R6");
    endtask

    task automatic t_size();
        defaults(); byte_sel = 1; ld_sel = 0; fire("R7");
        byte_sel = 0; ld_sel = 1; fire("R7");
    endtask

    task automatic t_priv();
        defaults(); pre_sel = 0; xlat_req = 1; fire("R8");
        xlat_req = 0; fire("R8");
        priv_in = 0; fire("R8");
    endtask

    task automatic t_pc_base();
        defaults(); base_is_pc = 1; base_val = 32'hDEAD_BEEF; imm_off = 12'h004; fire("R9");
        base_val = 32'h0123_4567; fire("R9");
        wb_req = 1; fire("R10");
        pre_sel = 0; wb_req = 0; fire("R10");
    endtask

    task automatic t_pre_xlat();
        defaults(); xlat_req = 1; pre_sel = 1; fire("R11");
        priv_in = 0; fire("R11");
    endtask

    task automatic t_hold();
        defaults(); imm_off = 12'h044; fire("R12");
        in_valid = 0; base_val = 32'h7777_0000; imm_off = 12'h001;
        @(negedge clk);
        check_one("R12", "idle valid", {31'd0, out_valid}, 32'd0);
        check_one("R12", "idle hold", xfer_addr, last_addr);
    endtask

    initial begin
        defaults();
        rst_n = 0; in_valid = 1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1; in_valid = 0;
        @(negedge clk);
        t_pre_index();
        t_post_index();
        t_wrap();
        t_shifts();
        t_shift_zero();
        t_size();
        t_priv();
        t_pc_base();
        t_pre_xlat();
        t_hold();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule